// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt request lines for an 8-bit processor bus and presents them to the CPU as a single active-low request. Every falling edge on a request line sets a pending latch for that line. A mask register stops chosen lines from raising the CPU request, but their latches still record the edge. A status read shows every pending latch and clears all of them at once. A polling read shows the vector that would be dispatched now, and it clears nothing.

The CPU takes an interrupt by fetching instructions from the controller's vector location. The controller answers three reads at that location with a long-branch instruction. The first byte is the opcode 0xC0. The second is the page register. The third is a low byte worked out from the control register and the highest-priority unmasked pending line. A cascade input takes the request output of a second controller in the chain. It acts as a ninth source, below every local line, and it is given its own vector slot.

The fetch sequencer has three states. FS_OPC returns the opcode and moves to FS_HI. FS_HI returns the page byte and moves to FS_LO. FS_LO returns the captured low byte and moves back to FS_OPC. A transition happens only on a read strobe at the fetch offset; at all other times the state holds.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A pending latch is set by a high-to-low change on its input, seen between two clock edges. A line held low, or a rising change, sets nothing more.
- R2: `int_n` is low when any pending line is unmasked or when `cascade_n` is low. Otherwise it is high.
- R3: A pending line whose mask bit is 1 stays latched (status bit i is 1) but does not pull `int_n` low.
- R4: A read at offset 3 returns the pending latches, with bit i for input i, and then clears them all. An edge arriving in the same cycle as the read is kept.
- R5: Priority is fixed. Input 7 is highest, input 0 is lowest, and the cascade slot comes below input 0.
- R6: Reads at offset 5 return 0xC0, then the page register (offset 0), then the low vector byte. The sequence then starts again at 0xC0.
- R7: Low vector byte = (control & 0xFC) + idx × (4 << control[1:0]), taken mod 256. Control is at offset 1, and control[1:0] = 0, 1, 2, 3 selects an interval of 4, 8, 16 or 32 bytes. idx is the winning input, or 8 when no unmasked local line is pending.
- R8: The opcode read captures the winner and clears only that winner's latch. The third byte returns the captured value even if new requests arrive in between.
- R9: A read at offset 4 returns the low vector byte of the current winner and leaves the latches unchanged.
- R10: The mask register is at offset 2, and a mask bit of 1 masks its line. Reads at offsets 0, 1, 2, 6 and 7 return 0x00. Writes to offsets 3 to 7 change nothing.
- R11: The cascade slot is dispatched only when no unmasked local line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Controller select strobe |
| wr | input | 1 | Write strobe, qualified by sel |
| rd | input | 1 | Read strobe, qualified by sel; one strobe is one access |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq_in | input | 8 | Request lines, latched on a falling edge |
| cascade_n | input | 1 | Active-low request from a chained controller |
| int_n | output | 1 | Active-low interrupt request to the CPU |

## Verification
The checks on clearing assume that `irq_in` sits high while reset is applied, because the edge detector comes out of reset believing every line was high. They also assume that a read strobe lasts exactly one cycle per access. The stimulus holds every line high through reset and for one clock after it. It raises each line again before that line's next falling edge, and it drives `rd` for a single cycle at a time, so each step of the fetch sequence and each clearing read happens exactly once.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [1:0] {
        FS_OPC = 2'd0,
        FS_HI  = 2'd1,
        FS_LO  = 2'd2
    } fetch_st_t;

    typedef enum logic [2:0] {
        RA_PAGE  = 3'd0,
        RA_CTRL  = 3'd1,
        RA_MASK  = 3'd2,
        RA_STAT  = 3'd3,
        RA_POLL  = 3'd4,
        RA_FETCH = 3'd5,
        RA_RSV6  = 3'd6,
        RA_RSV7  = 3'd7
    } reg_addr_t;

    localparam logic [7:0] LBR_OPCODE = 8'hC0;
endpackage

// File: rtl/vic_edge_latch.sv
module vic_edge_latch #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             clr_all,
    input  logic [N_SRC-1:0] clr_vec,
    output logic [N_SRC-1:0] pend
);
    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] fall;
    logic [N_SRC-1:0] clr_eff;

    assign fall    = prev_q & ~irq_in;
    assign clr_eff = clr_all ? {N_SRC{1'b1}} : clr_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= {N_SRC{1'b1}};
            pend   <= '0;
        end else begin
            prev_q <= irq_in;
            // a new edge wins over a clear in the same cycle
            pend   <= (pend & ~clr_eff) | fall;
        end
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N_SRC = 8,
    parameter int IW    = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0] req,
    output logic [IW-1:0]    win_idx,
    output logic [N_SRC-1:0] win_oh
);
    always_comb begin
        win_idx = IW'(N_SRC);
        win_oh  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i]) begin
                win_idx   = IW'(i);
                win_oh    = '0;
                win_oh[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vic_fetch_fsm.sv
module vic_fetch_fsm
    import vic_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fetch_rd,
    output fetch_st_t cur_st,
    output logic      capture
);
    fetch_st_t nxt_st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= FS_OPC;
        else        cur_st <= nxt_st;
    end

    always_comb begin
        nxt_st  = cur_st;
        capture = 1'b0;
        unique case (cur_st)
            FS_OPC: if (fetch_rd) begin
                nxt_st  = FS_HI;
                capture = 1'b1;
            end
            FS_HI:  if (fetch_rd) nxt_st = FS_LO;
            FS_LO:  if (fetch_rd) nxt_st = FS_OPC;
            default: nxt_st = FS_OPC;
        endcase
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int DW    = 8,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [N_SRC-1:0] irq_in,
    input  logic          cascade_n,
    output logic          int_n
);
    localparam int IW = $clog2(N_SRC + 1);
    localparam int SW = DW + IW;

    logic [DW-1:0]    page_q, ctrl_q, mask_q, low_cap_q;
    logic [N_SRC-1:0] pend, win_oh, clr_vec;
    logic [IW-1:0]    win_idx;
    logic [SW-1:0]    span;
    logic [2:0]       shamt;
    logic [DW-1:0]    base, low_live;
    logic             wr_hit, rd_hit, fetch_rd, clr_all, capture;
    reg_addr_t        a_sel;
    fetch_st_t        fetch_st;

    assign a_sel    = reg_addr_t'(addr[2:0]);
    assign wr_hit   = sel && wr;
    assign rd_hit   = sel && rd;
    assign fetch_rd = rd_hit && (a_sel == RA_FETCH);
    assign clr_all  = rd_hit && (a_sel == RA_STAT);
    assign clr_vec  = capture ? win_oh : '0;

    vic_edge_latch #(.N_SRC(N_SRC)) u_latch (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .clr_all(clr_all), .clr_vec(clr_vec), .pend(pend)
    );

    vic_prio #(.N_SRC(N_SRC), .IW(IW)) u_prio (
        .req(pend & ~mask_q), .win_idx(win_idx), .win_oh(win_oh)
    );

    vic_fetch_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .fetch_rd(fetch_rd),
        .cur_st(fetch_st), .capture(capture)
    );

    assign base     = {ctrl_q[DW-1:2], 2'b00};
    assign shamt    = {1'b0, ctrl_q[1:0]} + 3'd2;
    assign span     = SW'(win_idx) << shamt;
    assign low_live = base + span[DW-1:0];

    assign int_n = ~((|(pend & ~mask_q)) | ~cascade_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q    <= '0;
            ctrl_q    <= '0;
            mask_q    <= '0;
            low_cap_q <= '0;
        end else begin
            if (wr_hit) begin
                unique case (a_sel)
                    RA_PAGE: page_q <= wdata;
                    RA_CTRL: ctrl_q <= wdata;
                    RA_MASK: mask_q <= wdata;
                    default: ;
                endcase
            end
            if (capture) low_cap_q <= low_live;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (a_sel)
            RA_STAT:  rdata = DW'(pend);
            RA_POLL:  rdata = low_live;
            RA_FETCH: begin
                unique case (fetch_st)
                    FS_OPC:  rdata = LBR_OPCODE;
                    FS_HI:   rdata = page_q;
                    FS_LO:   rdata = low_cap_q;
                    default: rdata = '0;
                endcase
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             rd,
    input logic [2:0]       addr,
    input logic [7:0]       rdata,
    input logic [N_SRC-1:0] irq_in,
    input logic             cascade_n,
    input logic             int_n,
    input logic [N_SRC-1:0] pend,
    input logic [N_SRC-1:0] win_oh,
    input fetch_st_t        fetch_st
);
    // R2
    cascade_pulls_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cascade_n |-> !int_n);

    // R4
    status_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && addr == 3'd3 && $stable(irq_in)) |=> (pend == '0));

    // R6
    opcode_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && addr == 3'd5 && fetch_st == FS_OPC) |-> (rdata == 8'hC0));

    // R6
    hi_to_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && addr == 3'd5 && fetch_st == FS_HI) |=> (fetch_st == FS_LO));

    // R6
    lo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && addr == 3'd5 && fetch_st == FS_LO) |=> (fetch_st == FS_OPC));

    // R8
    winner_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && addr == 3'd5 && fetch_st == FS_OPC && (|win_oh) && $stable(irq_in))
        |=> ((pend & $past(win_oh)) == '0));
endmodule

bind vec_irq_ctrl vic_chk #(.N_SRC(N_SRC)) u_vic_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .addr(addr[2:0]),
    .rdata(rdata[7:0]), .irq_in(irq_in), .cascade_n(cascade_n), .int_n(int_n),
    .pend(pend), .win_oh(win_oh), .fetch_st(fetch_st)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] irq_in = 8'hFF;
    logic       cascade_n = 1'b1;
    logic       int_n;
    logic       probe = 1'b0;

    int nchk = 0;
    int nfail = 0;

    typedef struct {
        string      tag;
        logic [7:0] exp;
        bit         is_int;
    } exp_item_t;
    exp_item_t exp_q[$];

    always #10 clk = ~clk;

    vec_irq_ctrl i_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .cascade_n(cascade_n),
        .int_n(int_n)
    );

    function automatic logic [7:0] vlow(input logic [7:0] ctl, input int idx);
        int v;
        v = int'(ctl & 8'hFC) + idx * (4 << ctl[1:0]);
        return 8'(v % 256);
    endfunction

    // monitor: compare what the design shows against queued expectations
    always @(negedge clk) begin
        #5;
        if ((sel && rd) || probe) begin
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL scoreboard: result with no expectation");
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                nchk++;
                if (it.is_int) begin
                    if (int_n !== it.exp[0]) begin
                        nfail++;
                        $display("FAIL %s: int_n actual %b expected %b", it.tag, int_n, it.exp[0]);
                    end
                end else if (rdata !== it.exp) begin
                    nfail++;
                    $display("FAIL %s: rdata actual %02h expected %02h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = a;
        exp_q.push_back('{tag, e, 1'b0});
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic int_chk(input logic e, input string tag);
        @(negedge clk);
        probe = 1'b1;
        exp_q.push_back('{tag, {7'b0, e}, 1'b1});
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic drop(input logic [7:0] bits);
        @(negedge clk);
        irq_in = irq_in & ~bits;
    endtask

    task automatic raise_all();
        @(negedge clk);
        irq_in = 8'hFF;
        @(negedge clk);
    endtask

    task automatic fetch_chk(input logic [7:0] page, input logic [7:0] lo, input string tag);
        rd_chk(3'd5, 8'hC0, tag);
        rd_chk(3'd5, page, tag);
        rd_chk(3'd5, lo, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        int_chk(1'b1, "R2");
        rd_chk(3'd3, 8'h00, "R4");
        rd_chk(3'd4, vlow(8'h00, 8), "R9");

        // R10 register map and read-back of write-only registers
        wr_reg(3'd0, 8'h3A);
        wr_reg(3'd1, 8'h41);
        wr_reg(3'd2, 8'h00);
        rd_chk(3'd0, 8'h00, "R10");
        rd_chk(3'd1, 8'h00, "R10");
        rd_chk(3'd7, 8'h00, "R10");

        // R1 single edge, R9 poll, R6/R7 fetch
        drop(8'h04);
        int_chk(1'b0, "R1");
        rd_chk(3'd4, vlow(8'h41, 2), "R9");
        rd_chk(3'd4, vlow(8'h41, 2), "R9");
        fetch_chk(8'h3A, vlow(8'h41, 2), "R6");
        int_chk(1'b1, "R8");
        raise_all();

        // R5 fixed priority over three fetches
        drop(8'h2A);
        fetch_chk(8'h3A, vlow(8'h41, 5), "R5");
        fetch_chk(8'h3A, vlow(8'h41, 3), "R5");
        fetch_chk(8'h3A, vlow(8'h41, 1), "R5");
        int_chk(1'b1, "R8");
        raise_all();

        // R3 masked line latched but silent
        wr_reg(3'd2, 8'h80);
        drop(8'h80);
        int_chk(1'b1, "R3");
        rd_chk(3'd3, 8'h80, "R3");
        rd_chk(3'd3, 8'h00, "R4");
        raise_all();

        // R3 masked pending is passed over by the fetch
        drop(8'h81);
        int_chk(1'b0, "R3");
        fetch_chk(8'h3A, vlow(8'h41, 0), "R3");
        int_chk(1'b1, "R3");
        rd_chk(3'd3, 8'h80, "R4");
        raise_all();

        // R7 interval 32 and interval 4 with base
        wr_reg(3'd2, 8'h00);
        wr_reg(3'd1, 8'h03);
        drop(8'h80);
        rd_chk(3'd4, 8'hE0, "R7");
        wr_reg(3'd1, 8'h10);
        rd_chk(3'd4, 8'h10 + 8'd28, "R7");
        rd_chk(3'd3, 8'h80, "R4");
        raise_all();
        drop(8'h40);
        rd_chk(3'd4, 8'h28, "R7");
        rd_chk(3'd3, 8'h40, "R4");
        raise_all();

        // R8 captured low byte survives a higher request mid-sequence
        drop(8'h02);
        rd_chk(3'd5, 8'hC0, "R8");
        drop(8'h80);
        rd_chk(3'd5, 8'h3A, "R8");
        rd_chk(3'd5, vlow(8'h10, 1), "R8");
        rd_chk(3'd3, 8'h80, "R8");
        raise_all();

        // R11 cascade slot only without local requests
        @(negedge clk);
        cascade_n = 1'b0;
        int_chk(1'b0, "R2");
        rd_chk(3'd4, vlow(8'h10, 8), "R11");
        drop(8'h01);
        rd_chk(3'd4, vlow(8'h10, 0), "R11");
        fetch_chk(8'h3A, vlow(8'h10, 0), "R11");
        int_chk(1'b0, "R2");
        fetch_chk(8'h3A, vlow(8'h10, 8), "R11");
        @(negedge clk);
        cascade_n = 1'b1;
        int_chk(1'b1, "R2");
        raise_all();

        // R4 status clears everything; R1 held-low line does not re-latch
        wr_reg(3'd2, 8'h10);
        drop(8'h12);
        rd_chk(3'd3, 8'h12, "R4");
        int_chk(1'b1, "R4");
        rd_chk(3'd3, 8'h00, "R1");
        @(negedge clk);
        irq_in = 8'hFF;
        rd_chk(3'd3, 8'h00, "R1");

        // R10 writes to read-only offsets have no effect
        wr_reg(3'd3, 8'hFF);
        wr_reg(3'd4, 8'hFF);
        wr_reg(3'd5, 8'hFF);
        rd_chk(3'd3, 8'h00, "R10");
        int_chk(1'b1, "R10");
        fetch_chk(8'h3A, vlow(8'h10, 8), "R10");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            nfail++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule